// File: doc/BRIEF.md
# Masked Register Poll Unit

This unit carries out the poll step of a command engine. When the engine hands it a poll instruction, it reads a target register through a simple request/acknowledge read port. It keeps only the bits selected by a mask register and compares them with the expected value carried in the instruction. If they differ, it waits a programmed number of microseconds and reads again. The engine is released in one of two ways: with a plain completion pulse on a match, or with a completion pulse plus an error pulse once every allowed attempt has missed.

Two configuration registers are written a few slots before the poll instruction executes. The mask register holds the compare mask. The function register holds an enable bit, a retry count and an inter-attempt wait in microseconds. A microsecond is a fixed number of clock cycles set by a parameter. If the enable bit is clear, a poll instruction completes at once and performs no read.

Top module: `poll_unit`

## Requirements
- R1: After reset, `rd_req`, `busy`, `done` and `err` are all 0.
- R2: An instruction is taken only if `inst_hi[31:24]` equals 0x0A. An instruction with any other opcode is ignored: it causes no read, no `done` and no `busy`.
- R3: Function register fields: bit 31 is the enable, bits [16+CNT_W-1:16] hold the retry count, and bits [WAIT_W-1:0] hold the wait in microseconds. If the enable is 0 when a poll is taken, `done` pulses in the next cycle with `err` = 0 and no read is issued.
- R4: With the enable set, `rd_req` rises in the cycle after the instruction is taken. `rd_addr` equals `inst_hi[19:0]`, and the request is held with a stable address until `rd_ack`.
- R5: An attempt matches when `(rd_data & mask) == (inst_lo & mask)`. Read bits whose mask bit is 0 have no effect on the outcome.
- R6: On a matching read, `done` pulses in the cycle after `rd_ack`, with `err` = 0, and the unit returns to idle (`busy` = 0).
- R7: After a miss with attempts left, `rd_req` stays low for exactly wait × CYC_PER_US cycles before the next request. With a wait of 0, the next request follows at once and `rd_req` stays high.
- R8: The number of attempts allowed is the retry count plus one. After the last of them misses, `done` and `err` pulse together in the cycle after `rd_ack`, and the unit returns to idle.
- R9: An instruction presented while the unit is busy is ignored. The poll in progress keeps its address and outcome.
- R10: `done` and `err` are one-cycle pulses, and `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mask_we | input | 1 | Write strobe for the compare mask register |
| cfg_func_we | input | 1 | Write strobe for the function register |
| cfg_wdata | input | 32 | Configuration write data |
| inst_valid | input | 1 | Instruction present |
| inst_hi | input | 32 | Instruction high word: opcode [31:24], register address [19:0] |
| inst_lo | input | 32 | Instruction low word: expected value |
| busy | output | 1 | A poll is in progress |
| done | output | 1 | Completion pulse that releases the engine |
| err | output | 1 | Poll-error interrupt pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | 20 | Read address |
| rd_ack | input | 1 | Read acknowledge, with data valid |
| rd_data | input | 32 | Read data |

## Verification
A wrong attempt counter would show up as `done`/`err` arriving one read too early or too late. That difference is visible at the acknowledge of the final attempt. A timer loaded with the wrong value would show up as a gap on `rd_req` that is off by some cycles, so the bench counts every low cycle between requests. A compare that ignores the mask would finish on the wrong attempt, because the match data is deliberately corrupted in unmasked bits and the miss data differs in exactly one masked bit. A latch of the address or opcode that goes wrong would show on `rd_addr` during the first request, or as a spurious `busy` after a foreign opcode.

// File: rtl/poll_pkg.sv
package poll_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT
   } poll_state_e;

   localparam logic [7:0] POLL_OPCODE  = 8'h0A;
   localparam int         OPC_LSB      = 24;
   localparam int         FUNC_EN_BIT  = 31;
   localparam int         FUNC_CNT_LSB = 16;
endpackage

// File: rtl/poll_cfg.sv
module poll_cfg
   import poll_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WAIT_W = 10,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we,
   input  logic              func_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask,
   output logic              enable,
   output logic [WAIT_W-1:0] wait_us,
   output logic [CNT_W-1:0]  retries
);
   if (WAIT_W < 1 || WAIT_W > FUNC_CNT_LSB) begin : g_bad_wait
      $error("poll_cfg: WAIT_W must fit below the retry field");
   end
   if (CNT_W < 1 || FUNC_CNT_LSB + CNT_W > FUNC_EN_BIT) begin : g_bad_cnt
      $error("poll_cfg: CNT_W must fit below the enable bit");
   end

   logic [DATA_W-1:0] func_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask   <= '0;
         func_q <= '0;
      end else begin
         if (mask_we) mask   <= wdata;
         if (func_we) func_q <= wdata;
      end
   end

   assign enable  = func_q[FUNC_EN_BIT];
   assign wait_us = func_q[WAIT_W-1:0];
   assign retries = func_q[FUNC_CNT_LSB +: CNT_W];
endmodule

// File: rtl/poll_cmp.sv
module poll_cmp #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] expected,
   input  logic [DATA_W-1:0] mask,
   output logic              match
);
   logic [DATA_W-1:0] diff;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign diff[i] = mask[i] & (rd_data[i] ^ expected[i]);
   end

   assign match = ~|diff;
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [TMR_W-1:0] load,
   output logic             expired
);
   logic [TMR_W-1:0] cnt;
   logic             run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (start) begin
         cnt <= load;
         run <= 1'b1;
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - 1'b1;
      end
   end

   assign expired = run && (cnt == '0);

   // R7: a new wait never starts while one is still counting
   a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !run);
endmodule

// File: rtl/poll_unit.sv
module poll_unit
   import poll_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 20,
   parameter int WAIT_W     = 10,
   parameter int CNT_W      = 8,
   parameter int CYC_PER_US = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_mask_we,
   input  logic              cfg_func_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              inst_valid,
   input  logic [DATA_W-1:0] inst_hi,
   input  logic [DATA_W-1:0] inst_lo,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data
);
   localparam int CYC_W  = $clog2(CYC_PER_US + 1);
   localparam int TMR_W  = WAIT_W + CYC_W;
   localparam int LEFT_W = CNT_W + 1;
   localparam logic [LEFT_W-1:0] ONE_LEFT = LEFT_W'(1);

   if (DATA_W != 32) begin : g_bad_data
      $error("poll_unit: instruction words are 32 bits");
   end
   if (ADDR_W < 1 || ADDR_W > OPC_LSB) begin : g_bad_addr
      $error("poll_unit: ADDR_W must fit below the opcode");
   end
   if (CYC_PER_US < 1) begin : g_bad_cyc
      $error("poll_unit: CYC_PER_US must be at least 1");
   end

   logic [DATA_W-1:0] mask;
   logic              enable;
   logic [WAIT_W-1:0] wait_us;
   logic [CNT_W-1:0]  retries;
   logic              match;
   logic              expired;
   logic              tmr_start;
   logic [TMR_W-1:0]  tmr_load;
   logic              accept;
   logic              last_try;

   poll_state_e       state;
   logic [LEFT_W-1:0] left;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] exp_q;

   poll_cfg #(.DATA_W(DATA_W), .WAIT_W(WAIT_W), .CNT_W(CNT_W)) i_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (cfg_mask_we),
      .func_we (cfg_func_we),
      .wdata   (cfg_wdata),
      .mask    (mask),
      .enable  (enable),
      .wait_us (wait_us),
      .retries (retries)
   );

   poll_cmp #(.DATA_W(DATA_W)) i_cmp (
      .rd_data  (rd_data),
      .expected (exp_q),
      .mask     (mask),
      .match    (match)
   );

   poll_timer #(.TMR_W(TMR_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_start),
      .load    (tmr_load),
      .expired (expired)
   );

   assign accept    = (state == ST_IDLE) && inst_valid &&
                      (inst_hi[DATA_W-1:OPC_LSB] == POLL_OPCODE);
   assign last_try  = (left == ONE_LEFT);
   assign tmr_load  = TMR_W'(wait_us) * TMR_W'(CYC_PER_US) - TMR_W'(1);
   assign tmr_start = (state == ST_READ) && rd_ack && !match && !last_try &&
                      (wait_us != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         left   <= '0;
         addr_q <= '0;
         exp_q  <= '0;
         done   <= 1'b0;
         err    <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  addr_q <= inst_hi[ADDR_W-1:0];
                  exp_q  <= inst_lo;
                  if (!enable) begin
                     done <= 1'b1;
                  end else begin
                     state <= ST_READ;
                     left  <= {1'b0, retries} + ONE_LEFT;
                  end
               end
            end
            ST_READ: begin
               if (rd_ack) begin
                  if (match) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else if (last_try) begin
                     done  <= 1'b1;
                     err   <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     left  <= left - ONE_LEFT;
                     state <= (wait_us == '0) ? ST_READ : ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (expired) state <= ST_READ;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign rd_req  = (state == ST_READ);
   assign rd_addr = addr_q;

   // R8: a read is never issued with no attempt remaining
   a_r8_attempt_left: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (left != '0));
   // R10: the error pulse always comes with completion
   a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);
   // R6: completion leaves the unit idle
   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R4: a pending request keeps its address until acknowledged
   a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: tb/test_poll_unit.sv
module test_poll_unit;
   localparam int CLK_PERIOD = 10;
   localparam int CYC        = 3;
   localparam int WW         = 4;
   localparam int CW         = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_mask_we, cfg_func_we;
   logic [31:0] cfg_wdata;
   logic        inst_valid;
   logic [31:0] inst_hi, inst_lo;
   logic        busy, done, err, rd_req, rd_ack;
   logic [19:0] rd_addr;
   logic [31:0] rd_data;

   int checks = 0;
   int errs   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   poll_unit #(.WAIT_W(WW), .CNT_W(CW), .CYC_PER_US(CYC)) i_poll_unit (
      .clk(clk), .rst_n(rst_n),
      .cfg_mask_we(cfg_mask_we), .cfg_func_we(cfg_func_we), .cfg_wdata(cfg_wdata),
      .inst_valid(inst_valid), .inst_hi(inst_hi), .inst_lo(inst_lo),
      .busy(busy), .done(done), .err(err),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
      end
   endtask

   task automatic program_cfg(input logic [31:0] mask, input bit en, input int wt,
                              input int rtr);
      @(negedge clk);
      cfg_mask_we = 1'b1; cfg_wdata = mask;
      @(negedge clk);
      cfg_mask_we = 1'b0; cfg_func_we = 1'b1;
      cfg_wdata = ({31'd0, en} << 31) | (32'(rtr) << 16) | 32'(wt);
      @(negedge clk);
      cfg_func_we = 1'b0;
   endtask

   // hit: attempt (1-based) whose read matches; 0 = never
   task automatic run_poll(input logic [31:0] mask, input logic [31:0] expv,
                           input int wt, input int rtr, input int hit,
                           input int lat, input logic [19:0] addr);
      logic [31:0] lowbit;
      int          allowed;
      bit          fin, hitnow;
      int          g;
      lowbit  = mask & (~mask + 32'd1);
      allowed = rtr + 1;
      program_cfg(mask, 1'b1, wt, rtr);
      inst_valid = 1'b1; inst_hi = {8'h0A, 4'h0, addr}; inst_lo = expv;
      @(negedge clk);
      inst_valid = 1'b0;
      for (int a = 1; a <= allowed; a++) begin
         check(rd_req == 1'b1, "R4 request raised", 32'(rd_req), 32'd1);
         check(rd_addr == addr, "R4 address", 32'(rd_addr), 32'(addr));
         for (int l = 0; l < lat; l++) begin
            @(negedge clk);
            check(rd_req == 1'b1 && done == 1'b0, "R4 request held", 32'(rd_req), 32'd1);
         end
         hitnow = (hit == a) || (mask == 32'd0);
         rd_ack  = 1'b1;
         // R5: match data differs only in unmasked bits, miss data in one masked bit
         rd_data = hitnow ? (expv ^ ~mask) : (expv ^ lowbit);
         fin = hitnow || (a == allowed);
         @(negedge clk);
         rd_ack = 1'b0;
         if (fin) begin
            check(done == 1'b1, hitnow ? "R6 done on match" : "R8 done on exhaust",
                  32'(done), 32'd1);
            check(err == !hitnow, hitnow ? "R5 no err on match" : "R8 err on exhaust",
                  32'(err), 32'(!hitnow));
            check(busy == 1'b0, "R6 idle after finish", 32'(busy), 32'd0);
            @(negedge clk);
            check(done == 1'b0 && err == 1'b0, "R10 single pulse",
                  {30'd0, done, err}, 32'd0);
            return;
         end
         check(done == 1'b0, "R8 no early done", 32'(done), 32'd0);
         g = 0;
         while (!rd_req && g < 1000) begin
            g++;
            @(negedge clk);
         end
         check(g == wt * CYC, "R7 wait gap", 32'(g), 32'(wt * CYC));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [31:0] masks [3];
      int          g;
      masks[0] = 32'hFFFF_FFFF; masks[1] = 32'h0000_00F0; masks[2] = 32'h8000_0001;
      rst_n = 1'b0; cfg_mask_we = 0; cfg_func_we = 0; cfg_wdata = 0;
      inst_valid = 0; inst_hi = 0; inst_lo = 0; rd_ack = 0; rd_data = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({rd_req, busy, done, err} == 4'd0, "R1 reset state",
            {28'd0, rd_req, busy, done, err}, 32'd0);

      // R2: foreign opcode ignored
      program_cfg(32'hFFFF_FFFF, 1'b1, 1, 1);
      inst_valid = 1'b1; inst_hi = {8'h0B, 4'h0, 20'h12345}; inst_lo = 32'h1;
      @(negedge clk);
      inst_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         check({rd_req, busy, done} == 3'd0, "R2 other opcode ignored",
               {29'd0, rd_req, busy, done}, 32'd0);
         @(negedge clk);
      end

      // R3: disabled poll completes without reading
      program_cfg(32'hFFFF_FFFF, 1'b0, 2, 3);
      inst_valid = 1'b1; inst_hi = {8'h0A, 4'h0, 20'h00ABC}; inst_lo = 32'h5;
      @(negedge clk);
      inst_valid = 1'b0;
      check(done == 1'b1 && err == 1'b0, "R3 disabled done", {30'd0, done, err}, 32'd2);
      check(rd_req == 1'b0 && busy == 1'b0, "R3 disabled no read",
            {30'd0, rd_req, busy}, 32'd0);
      @(negedge clk);
      check(done == 1'b0 && rd_req == 1'b0, "R3 disabled quiet after",
            {30'd0, done, rd_req}, 32'd0);

      // R9: instruction while busy ignored
      program_cfg(32'hFFFF_FFFF, 1'b1, 2, 1);
      inst_valid = 1'b1; inst_hi = {8'h0A, 4'h0, 20'h0AAAA}; inst_lo = 32'hC0DE;
      @(negedge clk);
      inst_valid = 1'b1; inst_hi = {8'h0A, 4'h0, 20'h05555}; inst_lo = 32'h0;
      rd_ack = 1'b1; rd_data = 32'h0;
      @(negedge clk);
      rd_ack = 1'b0;
      @(negedge clk);
      inst_valid = 1'b0;
      g = 0;
      while (!rd_req && g < 100) begin g++; @(negedge clk); end
      check(rd_addr == 20'h0AAAA, "R9 address kept", 32'(rd_addr), 32'h0AAAA);
      rd_ack = 1'b1; rd_data = 32'hC0DE;
      @(negedge clk);
      rd_ack = 1'b0;
      check(done == 1'b1 && err == 1'b0, "R9 original outcome", {30'd0, done, err}, 32'd2);
      @(negedge clk);
      check(busy == 1'b0, "R9 no second poll", 32'(busy), 32'd0);

      // R5: zero mask matches at once
      run_poll(32'd0, 32'hDEAD_BEEF, 2, 3, 0, 1, 20'h00F00);

      // sweep: masks, waits, retries, matching attempt, ack latency
      for (int m = 0; m < 3; m++)
         for (int wt = 0; wt < 3; wt++)
            foreach (masks[r]) begin
               int rtr;
               rtr = (r == 0) ? 0 : (r == 1) ? 1 : 3;
               for (int h = 0; h <= rtr + 1; h++)
                  run_poll(masks[m], 32'h3C5A_9610 ^ 32'(h * 7 + wt), wt, rtr, h,
                           (h + wt) % 3, 20'(20'h100 * (m + 1) + h));
            end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule